// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Engine

This block is the target side of a three-wire serial EEPROM: a select line, a shift clock, a serial data input and a serial data output. It oversamples those pins with the system clock. A select session holds one command: a start bit, a two-bit opcode, an address field and, for the two write commands, a data field. The command runs against a small on-chip register array, and the block reports read data and programming status on the data output.

A static width input picks between 16-bit words and 8-bit bytes. Both views alias the same storage. Programming commands are gated by an enable latch, and each one starts a self-timed busy period whose length is a parameter in system clocks. During that period the host polls ready or busy by raising select again. The data output is a drive enable plus a value, so the caller builds the tri-state pad.

Top module: `mwire_eeprom_target`

## Requirements
- R1: With select high, data-in is sampled on each rising shift-clock edge. Zeros before the first 1 are skipped, and that 1 is the start bit. Two opcode bits follow, then the address MSB first. The address is WORD_ADDR_W bits when orgWide=1 and WORD_ADDR_W+1 bits when orgWide=0. Write data follows the address, MSB first: 16 bits when orgWide=1, 8 bits when orgWide=0.
- R2: Opcode 2'b10 is a read. From the rising edge that samples the last address bit, doOe is 1 and doVal is a single 0. Each later rising edge presents the next data bit, MSB first. 16-bit word a occupies byte addresses 2a (high byte) and 2a+1 (low byte).
- R3: While select stays high after the last bit of a read word, the next rising edge presents the MSB of the following address, with no 0 in between. The address wraps from the highest location to 0.
- R4: Opcode 2'b01 stores the data field at the addressed location when programming is enabled.
- R5: Opcode 2'b11 sets every bit of the addressed location to 1 when programming is enabled.
- R6: Opcode 2'b00 is decoded by the two most significant address bits. Value 2'b11 enables programming and 2'b00 disables it. While programming is disabled, write, erase, erase-all and write-all change nothing and start no busy period. The enable setting holds until changed.
- R7: Opcode 2'b00 with top bits 2'b10 sets the whole array to ones. With top bits 2'b01, it is followed by a data field that is written to every location. In 16-bit mode this covers every word; in 8-bit mode it covers every byte.
- R8: A read returns stored data whether programming is enabled or disabled.
- R9: A programming command starts a busy period of PROG_CYCLES system clocks. For a write-type command it starts after the last data bit; for an erase it starts after the last address bit. If select is raised while busy, doOe is 1 and doVal is 0 until the period ends, then 1. Data-in is ignored for the rest of that session.
- R10: When select is low, doOe is 0. When select rises while the block is not busy, doOe stays 0 until a read begins.
- R11: If select falls before a command is complete, the command is dropped: no location changes and no busy period starts.
- R12: After reset every stored bit is 1, programming is disabled and doOe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| orgWide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes; static during a session |
| csIn | input | 1 | Select pin, asynchronous |
| sckIn | input | 1 | Shift clock pin, asynchronous |
| diIn | input | 1 | Serial data input pin, asynchronous |
| doOe | output | 1 | Drive enable for the serial output |
| doVal | output | 1 | Value of the serial output when driven |

## Verification
The bench streams reads across word boundaries and across the top address in both widths. A design that re-inserted the leading 0 between words, or failed to wrap, would shift every later bit. It polls status while a second command is clocked in during the busy period, which catches designs that accept commands while busy or report ready early. It drops select in the middle of a data field and writes while programming is disabled; a design that commits partial or ungated data would corrupt a location or show a busy status afterwards. It also checks byte and word aliasing and write-all in both widths, which exposes wrong byte order or an unfilled half word.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic clrRegs;
    logic shOpc;
    logic shAddr;
    logic shData;
    logic loadRd;
    logic shOut;
    logic showStat;
    logic doWr;
    logic doErase;
    logic doEral;
    logic doWral;
  } mwe_ctl_t;
endpackage

// File: rtl/mwe_ctrl.sv
module mwe_ctrl
  import mwe_pkg::*;
#(
  parameter int WORD_ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       orgWide,
  input  logic       csIn,
  input  logic       sckIn,
  input  logic       diIn,
  input  logic [1:0] opc,
  input  logic [1:0] addrTop2,
  input  logic       busy,
  output mwe_ctl_t   ctl,
  output logic       diBit,
  output logic       doOe
);
  localparam int CW = $clog2(WORD_ADDR_W + 18);
  localparam logic [CW-1:0] ADDR_LAST_W = CW'(WORD_ADDR_W - 1);
  localparam logic [CW-1:0] ADDR_LAST_B = CW'(WORD_ADDR_W);
  localparam logic [CW-1:0] DATA_LAST_W = CW'(WORD_W - 1);
  localparam logic [CW-1:0] DATA_LAST_B = CW'(BYTE_W - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_OPC, ST_ADDR, ST_ADEC,
    ST_DATA, ST_DDEC, ST_READ, ST_HOLD, ST_STAT
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          progEn;
  logic [1:0]    csQ;
  logic [2:0]    sckQ;
  logic [1:0]    diQ;
  logic          csS, sckRise;
  logic [CW-1:0] addrLast, dataLast;

  // two-flop synchronisers; sckQ[2] is the previous synced value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ  <= '0;
      sckQ <= '0;
      diQ  <= '0;
    end else begin
      csQ  <= {csQ[0], csIn};
      sckQ <= {sckQ[1:0], sckIn};
      diQ  <= {diQ[0], diIn};
    end
  end

  assign csS      = csQ[1];
  assign sckRise  = sckQ[1] & ~sckQ[2];
  assign diBit    = diQ[1];
  assign addrLast = orgWide ? ADDR_LAST_W : ADDR_LAST_B;
  assign dataLast = orgWide ? DATA_LAST_W : DATA_LAST_B;
  assign doOe     = (state == ST_READ) || (state == ST_STAT);

  always_comb begin
    ctl = '0;
    ctl.showStat = (state == ST_STAT);
    unique case (state)
      ST_START: ctl.clrRegs = sckRise & diBit;
      ST_OPC:   ctl.shOpc   = sckRise;
      ST_ADDR:  ctl.shAddr  = sckRise;
      ST_ADEC: begin
        ctl.loadRd  = (opc == 2'b10);
        ctl.doErase = (opc == 2'b11) && progEn;
        ctl.doEral  = (opc == 2'b00) && (addrTop2 == 2'b10) && progEn;
      end
      ST_DATA:  ctl.shData  = sckRise;
      ST_DDEC: begin
        ctl.doWr   = (opc == 2'b01) && progEn;
        ctl.doWral = (opc == 2'b00) && progEn;
      end
      ST_READ:  ctl.shOut   = sckRise;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      progEn <= 1'b0;
    end else if (!csS) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  state <= busy ? ST_STAT : ST_START;
        ST_START: if (sckRise && diBit) begin
          state <= ST_OPC;
          cnt   <= '0;
        end
        ST_OPC: if (sckRise) begin
          if (cnt == CW'(1)) begin
            state <= ST_ADDR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ADDR: if (sckRise) begin
          if (cnt == addrLast) state <= ST_ADEC;
          else cnt <= cnt + 1'b1;
        end
        ST_ADEC: begin
          cnt <= '0;
          unique case (opc)
            2'b10: state <= ST_READ;
            2'b01: state <= ST_DATA;
            2'b11: state <= ST_HOLD;
            default: begin
              state <= (addrTop2 == 2'b01) ? ST_DATA : ST_HOLD;
              if (addrTop2 == 2'b11) progEn <= 1'b1;
              if (addrTop2 == 2'b00) progEn <= 1'b0;
            end
          endcase
        end
        ST_DATA: if (sckRise) begin
          if (cnt == dataLast) state <= ST_DDEC;
          else cnt <= cnt + 1'b1;
        end
        ST_DDEC: state <= ST_HOLD;
        default: ;
      endcase
    end
  end

  // R9
  no_op_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doWr || ctl.doErase || ctl.doEral || ctl.doWral) |-> !busy);
  // R7
  op_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doWr, ctl.doErase, ctl.doEral, ctl.doWral, ctl.loadRd}));
  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> !doOe);
  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRd |=> doOe);
endmodule

// File: rtl/mwe_datapath.sv
module mwe_datapath
  import mwe_pkg::*;
#(
  parameter int WORD_ADDR_W = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       orgWide,
  input  mwe_ctl_t   ctl,
  input  logic       diBit,
  output logic [1:0] opc,
  output logic [1:0] addrTop2,
  output logic       busy,
  output logic       doVal
);
  localparam int BYTE_AW = WORD_ADDR_W + 1;
  localparam int NBYTES  = 1 << BYTE_AW;
  localparam int TW      = $clog2(PROG_CYCLES + 1);
  localparam int OW      = WORD_W + 1;

  logic [1:0]         opcReg;
  logic [BYTE_AW-1:0] addrReg, rdAddr, nextAddr;
  logic [WORD_W-1:0]  dataReg, curWord, nextWord;
  logic [OW-1:0]      outSr;
  logic [4:0]         rdCnt, nBits;
  logic [TW-1:0]      progCnt;
  logic [BYTE_W-1:0]  mem [NBYTES];
  logic               startProg;

  function automatic logic [WORD_W-1:0] fetch(input logic [BYTE_AW-1:0] a);
    if (orgWide) return {mem[{a[WORD_ADDR_W-1:0], 1'b0}], mem[{a[WORD_ADDR_W-1:0], 1'b1}]};
    return {{(WORD_W-BYTE_W){1'b0}}, mem[a]};
  endfunction

  assign opc       = opcReg;
  assign addrTop2  = orgWide ? addrReg[WORD_ADDR_W-1 -: 2] : addrReg[BYTE_AW-1 -: 2];
  assign nBits     = orgWide ? 5'd16 : 5'd8;
  assign curWord   = fetch(addrReg);
  assign nextAddr  = orgWide ? {1'b0, rdAddr[WORD_ADDR_W-1:0] + 1'b1} : rdAddr + 1'b1;
  assign nextWord  = fetch(nextAddr);
  assign busy      = (progCnt != '0);
  assign startProg = ctl.doWr | ctl.doErase | ctl.doEral | ctl.doWral;
  assign doVal     = ctl.showStat ? !busy : outSr[OW-1];

  // command field capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else if (ctl.clrRegs) begin
      opcReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.shOpc)  opcReg  <= {opcReg[0], diBit};
      if (ctl.shAddr) addrReg <= {addrReg[BYTE_AW-2:0], diBit};
      if (ctl.shData) dataReg <= {dataReg[WORD_W-2:0], diBit};
    end
  end

  // read output shifter: leading 0 only on the first word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr  <= '0;
      rdCnt  <= '0;
      rdAddr <= '0;
    end else if (ctl.loadRd) begin
      outSr  <= orgWide ? {1'b0, curWord} : {1'b0, curWord[BYTE_W-1:0], {BYTE_W{1'b0}}};
      rdCnt  <= '0;
      rdAddr <= orgWide ? {1'b0, addrReg[WORD_ADDR_W-1:0]} : addrReg;
    end else if (ctl.shOut) begin
      if (rdCnt == nBits) begin
        outSr  <= orgWide ? {nextWord, 1'b0} : {nextWord[BYTE_W-1:0], {(BYTE_W+1){1'b0}}};
        rdAddr <= nextAddr;
        rdCnt  <= 5'd1;
      end else begin
        outSr <= outSr << 1;
        rdCnt <= rdCnt + 1'b1;
      end
    end
  end

  // storage array, updated when a programming cycle is launched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '1;
    end else if (ctl.doWr || ctl.doErase) begin
      if (orgWide) begin
        mem[{addrReg[WORD_ADDR_W-1:0], 1'b0}] <= ctl.doErase ? '1 : dataReg[WORD_W-1:BYTE_W];
        mem[{addrReg[WORD_ADDR_W-1:0], 1'b1}] <= ctl.doErase ? '1 : dataReg[BYTE_W-1:0];
      end else begin
        mem[addrReg] <= ctl.doErase ? '1 : dataReg[BYTE_W-1:0];
      end
    end else if (ctl.doEral || ctl.doWral) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (ctl.doEral) mem[i] <= '1;
        else if (orgWide && !i[0]) mem[i] <= dataReg[WORD_W-1:BYTE_W];
        else mem[i] <= dataReg[BYTE_W-1:0];
      end
    end
  end

  // self-timed programming interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progCnt <= '0;
    else if (startProg) progCnt <= TW'(PROG_CYCLES);
    else if (busy) progCnt <= progCnt - 1'b1;
  end

  // R9
  prog_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startProg |=> busy);
  // R9
  prog_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(progCnt) == TW'(1)));
  // R3
  stream_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shOut |-> (rdCnt <= nBits));
endmodule

// File: rtl/mwire_eeprom_target.sv
module mwire_eeprom_target
  import mwe_pkg::*;
#(
  parameter int WORD_ADDR_W = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic orgWide,
  input  logic csIn,
  input  logic sckIn,
  input  logic diIn,
  output logic doOe,
  output logic doVal
);
  mwe_ctl_t   ctl;
  logic       diBit, busy;
  logic [1:0] opc, addrTop2;

  mwe_ctrl #(.WORD_ADDR_W(WORD_ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .csIn(csIn), .sckIn(sckIn),
    .diIn(diIn), .opc(opc), .addrTop2(addrTop2), .busy(busy), .ctl(ctl),
    .diBit(diBit), .doOe(doOe)
  );

  mwe_datapath #(.WORD_ADDR_W(WORD_ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .ctl(ctl), .diBit(diBit),
    .opc(opc), .addrTop2(addrTop2), .busy(busy), .doVal(doVal)
  );
endmodule

// File: tb/mwire_eeprom_target_bench.sv
module mwire_eeprom_target_bench;
  localparam int AW = 6;
  localparam int PROG = 600;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, orgWide = 1'b1;
  logic csIn = 1'b0, sckIn = 1'b0, diIn = 1'b0;
  logic doOe, doVal;

  always #10 clk = ~clk;

  mwire_eeprom_target #(.WORD_ADDR_W(AW), .PROG_CYCLES(PROG)) u_mwire_eeprom_target (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .csIn(csIn), .sckIn(sckIn),
    .diIn(diIn), .doOe(doOe), .doVal(doVal)
  );

  typedef struct { logic oe; logic val; string tag; } exp_t;
  exp_t expQ[$];
  event sampleEv;
  int nRun = 0, nFail = 0;
  logic [7:0] model [128];
  bit modelEn = 0;

  task automatic chkVal(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected output items and compares at each sample point
  initial forever begin
    @(sampleEv);
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      if (e.oe) chkVal(e.tag, {30'b0, doOe, doVal}, {30'b0, 1'b1, e.val});
      else chkVal(e.tag, {31'b0, doOe}, 32'b0);
    end
  end

  task automatic expectDo(logic oe, logic val, string tag);
    exp_t e;
    e.oe = oe; e.val = val; e.tag = tag;
    expQ.push_back(e);
    ->sampleEv;
    #1;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sckBit(logic d);
    diIn = d;
    waitClk(HALF);
    sckIn = 1'b1;
    waitClk(HALF);
    sckIn = 1'b0;
  endtask

  task automatic csOn();  csIn = 1'b1; waitClk(6); endtask
  task automatic csOff(); csIn = 1'b0; diIn = 1'b0; waitClk(6); endtask

  function automatic int addrBits(); return orgWide ? AW : AW + 1; endfunction

  task automatic sendHead(logic [1:0] opc, int addr);
    sckBit(1'b1);
    sckBit(opc[1]);
    sckBit(opc[0]);
    for (int i = addrBits() - 1; i >= 0; i--) sckBit(addr[i]);
  endtask

  task automatic sendData(logic [15:0] d, int nb);
    for (int i = nb - 1; i >= 0; i--) sckBit(d[i]);
  endtask

  task automatic session(logic [1:0] opc, int addr, logic [15:0] d, bit hasData);
    csOn();
    sendHead(opc, addr);
    if (hasData) sendData(d, orgWide ? 16 : 8);
    csOff();
  endtask

  function automatic logic [15:0] mword(int a);
    if (orgWide) return {model[2*a], model[2*a+1]};
    return {8'h00, model[a]};
  endfunction

  task automatic mstore(int a, logic [15:0] d);
    if (!modelEn) return;
    if (orgWide) begin model[2*a] = d[15:8]; model[2*a+1] = d[7:0]; end
    else model[a] = d[7:0];
  endtask

  task automatic writeWord(int a, logic [15:0] d);
    mstore(a, d);
    session(2'b01, a, d, 1);
    waitClk(PROG + 20);
  endtask

  task automatic eraseWord(int a);
    mstore(a, 16'hFFFF);
    session(2'b11, a, 16'h0, 0);
    waitClk(PROG + 20);
  endtask

  task automatic cmd00(logic [1:0] top, logic [15:0] d, bit hasData);
    session(2'b00, int'(top) << (addrBits() - 2), d, hasData);
  endtask

  task automatic fillAll(logic [15:0] d);
    if (!modelEn) return;
    for (int i = 0; i < 128; i++) model[i] = (orgWide && (i % 2 == 0)) ? d[15:8] : d[7:0];
  endtask

  task automatic readWords(int addr, int count, string tag, int lead = 0);
    int a = addr;
    int n = orgWide ? 16 : 8;
    logic [15:0] w;
    csOn();
    repeat (lead) sckBit(1'b0);
    sendHead(2'b10, addr);
    diIn = 1'b0;
    waitClk(HALF);
    expectDo(1'b1, 1'b0, {tag, " dummy"});
    for (int k = 0; k < count; k++) begin
      w = mword(a);
      for (int b = n - 1; b >= 0; b--) begin
        sckIn = 1'b1; waitClk(HALF);
        sckIn = 1'b0; waitClk(HALF);
        expectDo(1'b1, w[b], tag);
      end
      a = orgWide ? (a + 1) % 64 : (a + 1) % 128;
    end
    csOff();
    expectDo(1'b0, 1'b0, "R10 released after read");
  endtask

  task automatic idleProbe(string tag);
    csOn();
    expectDo(1'b0, 1'b0, tag);
    csOff();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL all requirements: watchdog expired actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    waitClk(5);
    expectDo(1'b0, 1'b0, "R12 output off in reset");
    rstN = 1'b1;
    waitClk(5);
    expectDo(1'b0, 1'b0, "R12 output off after reset");

    // R1 R12: leading zeros before start bit, erased content after reset
    readWords(5, 1, "R1 R12 leading zeros read", 3);

    // R6: programming disabled after reset
    writeWord(3, 16'h1111);
    idleProbe("R6 no busy while disabled");
    readWords(3, 1, "R6 disabled write ignored");

    // R6 enable, R4 write with R9 status polling
    cmd00(2'b11, 16'h0, 0); modelEn = 1;
    mstore(5, 16'hA53C);
    session(2'b01, 5, 16'hA53C, 1);
    csOn();
    expectDo(1'b1, 1'b0, "R9 busy status");
    waitClk(PROG);
    expectDo(1'b1, 1'b1, "R9 ready status");
    csOff();
    expectDo(1'b0, 1'b0, "R10 off with select low");
    readWords(5, 1, "R4 written word");

    // R3 sequential and wrap
    writeWord(6, 16'h1234);
    writeWord(63, 16'hBEEF);
    readWords(5, 3, "R3 sequential stream");
    readWords(63, 2, "R3 wrap to zero");

    // R5 erase one location
    eraseWord(5);
    readWords(5, 2, "R5 erased word");

    // R2 byte view aliasing
    orgWide = 1'b0;
    waitClk(4);
    readWords(12, 2, "R2 byte order");
    writeWord(127, 16'h005A);
    readWords(126, 3, "R3 byte wrap");
    orgWide = 1'b1;
    waitClk(4);
    readWords(63, 1, "R2 word from bytes");

    // R11 abort during data field
    csOn();
    sendHead(2'b01, 7);
    sendData(16'h0015, 5);
    csOff();
    idleProbe("R11 no busy after abort");
    readWords(7, 1, "R11 aborted write");

    // R9 command sent while busy is ignored
    mstore(20, 16'h7777);
    session(2'b01, 20, 16'h7777, 1);
    csOn();
    sendHead(2'b01, 9);
    sendData(16'h0000, 16);
    expectDo(1'b1, 1'b0, "R9 still busy during ignored command");
    waitClk(PROG);
    expectDo(1'b1, 1'b1, "R9 ready after ignored command");
    csOff();
    readWords(9, 1, "R9 ignored write");
    readWords(20, 1, "R9 accepted write");

    // R7 write-all and erase-all in both widths
    fillAll(16'h0F0F);
    cmd00(2'b01, 16'h0F0F, 1);
    waitClk(PROG + 20);
    readWords(62, 3, "R7 write-all words");
    orgWide = 1'b0;
    waitClk(4);
    fillAll(16'h003C);
    cmd00(2'b01, 16'h003C, 1);
    waitClk(PROG + 20);
    orgWide = 1'b1;
    waitClk(4);
    readWords(30, 1, "R7 write-all bytes");
    fillAll(16'hFFFF);
    cmd00(2'b10, 16'h0, 0);
    waitClk(PROG + 20);
    readWords(10, 2, "R7 erase-all");

    // R6 disable, R8 read still works
    writeWord(4, 16'h4242);
    cmd00(2'b00, 16'h0, 0); modelEn = 0;
    writeWord(4, 16'h0000);
    eraseWord(4);
    idleProbe("R6 no busy after disable");
    readWords(4, 1, "R8 read while disabled");

    waitClk(10);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule